// File: doc/BRIEF.md
# Per-Thread Fetch Status Controller

This block keeps the front-end fetch status of every hardware thread in a multithreaded core. Each thread has its own state machine. The machine reacts to stall pulses from four downstream stages, to squash requests, to the issue and completion of instruction-cache line requests, to trap and quiesce events, and to wake-ups. The block drives the current status of every thread and a single flag. The flag tells the surrounding pipeline whether the fetch stage has useful work this cycle.

Each thread holds four sticky stall bits, one per downstream stage (decode, rename, execute, commit). A block pulse sets a bit and an unblock pulse clears it. A line request that the cache rejects puts the thread into a retry wait and sets a shared cache-blocked flag. A later retry or a squash of that thread clears the flag. Every cache response carries a thread index and a request ID. A response is taken only when the thread is still waiting and the ID matches the request it issued. Any other response is dropped and reported with a one-cycle pulse.

Top module: `fetch_thread_status`

## Requirements
- R1: After a synchronous active-low reset, every thread is Running, all stall bits are clear and the cache-blocked flag is low. Thread t's status is status_o[4t+3:4t], encoded Running=0, Idle=1, Squashing=2, Blocked=3, WaitResponse=4, WaitRetry=5, AccessComplete=6, TrapPending=7, QuiescePending=8.
- R2: Stall bit s of thread t sits at stall_bits_o[4t+s]. Stage s is decode=0, rename=1, execute=2, commit=3. Pulse block_i[4t+s] sets the bit and unblock_i[4t+s] clears it; block wins when both pulse. A thread is stalled when any of its updated bits is set or ctx_switch_i is high. A stalled thread in Running, Idle, Blocked, Squashing or AccessComplete goes to Blocked. A Blocked or Squashing thread that sees no squash and no stall returns to Running.
- R3: A commit squash, a still-squashing indication or a decode squash moves the thread to Squashing. These take priority over every other event in that cycle, including stalls and cache responses.
- R4: While commit_still_squash_i is high for a thread, that thread stays in Squashing.
- R5: On a fetch turn (turn_valid_i with turn_tid_i) with req_i, a Running thread issues a line request with ID req_id_i. It goes to WaitResponse if req_accept_i is high. Otherwise it goes to WaitRetry and sets cache_blocked_o. While cache_blocked_o is high, new requests are ignored.
- R6: A response is accepted only when the addressed thread is in WaitResponse, its ID equals the stored request ID, and no squash hits the thread that cycle. Any other response raises resp_drop_o in the same cycle and leaves the thread's state untouched.
- R7: An accepted response moves the thread to Blocked if it is stalled and to AccessComplete otherwise. A stall does not move a thread out of WaitResponse. AccessComplete becomes Running on the thread's next fetch turn.
- R8: A successful retry (retry_i and retry_ok_i while cache_blocked_o is high) moves the retrying thread from WaitRetry to WaitResponse and clears cache_blocked_o. A squash of the retrying thread also clears the flag.
- R9: A fault moves a Running thread to TrapPending and a quiesce moves it to QuiescePending. Either state is left only through a squash (to Squashing) or wake_i (to Running). Stalls do not affect them.
- R10: stage_active_o is high exactly when some thread whose thread_active_i bit is set is Running, Squashing or AccessComplete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| thread_active_i | input | NUM_THREADS | Threads taking part in the stage-active decision |
| block_i | input | 4*NUM_THREADS | Block pulses, bit 4t+s |
| unblock_i | input | 4*NUM_THREADS | Unblock pulses, bit 4t+s |
| ctx_switch_i | input | 1 | Context switch in progress, stalls all threads |
| commit_squash_i | input | NUM_THREADS | Squash from commit per thread |
| commit_still_squash_i | input | NUM_THREADS | Commit side still squashing per thread |
| decode_squash_i | input | NUM_THREADS | Squash from decode per thread |
| turn_valid_i | input | 1 | A fetch turn is granted this cycle |
| turn_tid_i | input | TID_W | Thread owning the fetch turn |
| req_i | input | 1 | The turn wants a line request |
| req_accept_i | input | 1 | Cache accepts the request this cycle |
| req_id_i | input | REQ_ID_W | ID of the issued request |
| retry_i | input | 1 | Cache signals a retry attempt |
| retry_ok_i | input | 1 | The retried request was accepted |
| resp_valid_i | input | 1 | Cache response valid |
| resp_tid_i | input | TID_W | Thread of the response |
| resp_id_i | input | REQ_ID_W | Request ID of the response |
| fault_i | input | NUM_THREADS | Fault detected per thread |
| quiesce_i | input | NUM_THREADS | Quiesce instruction seen per thread |
| wake_i | input | NUM_THREADS | Wake from trap or quiesce per thread |
| status_o | output | 4*NUM_THREADS | Per-thread status code |
| stall_bits_o | output | 4*NUM_THREADS | Per-thread sticky stall bits |
| stage_active_o | output | 1 | Fetch stage has work |
| cache_blocked_o | output | 1 | A rejected request awaits retry |
| resp_drop_o | output | 1 | A response was discarded this cycle |

## Verification
The bench builds the block with NUM_THREADS=2 and REQ_ID_W=3. Two threads let one thread hold the shared cache-blocked flag while the other tries to issue. They also allow responses and squashes to be aimed at one thread while the other is checked for being undisturbed. Three ID bits are enough to send a mismatching ID, and a matching ID after a squash, to show that stale responses are discarded.

// File: rtl/fts_pkg.sv
// Shared types for the per-thread fetch status controller.
// Assumes: four downstream stages, status fits in four bits.
package fts_pkg;

    localparam int NUM_STAGES = 4;
    localparam int STATE_W    = 4;

    typedef enum logic [STATE_W-1:0] {
        ST_RUN        = 4'd0,
        ST_IDLE       = 4'd1,
        ST_SQUASH     = 4'd2,
        ST_BLOCKED    = 4'd3,
        ST_WAIT_RESP  = 4'd4,
        ST_WAIT_RETRY = 4'd5,
        ST_ACC_DONE   = 4'd6,
        ST_TRAP       = 4'd7,
        ST_QUIESCE    = 4'd8
    } fstate_e;

    // True for states in which the fetch stage has work to do.
    function automatic logic is_live(input fstate_e s);
        return (s == ST_RUN) || (s == ST_SQUASH) || (s == ST_ACC_DONE);
    endfunction

endpackage

// File: rtl/fts_stall_bits.sv
// Sticky stall bits of one thread, one bit per downstream stage.
// Block pulse sets, unblock pulse clears, block wins on a tie.
// Also exposes the value after this cycle's pulses so the state
// machine can react in the same cycle.
module fts_stall_bits #(
    parameter int NSTG = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSTG-1:0] block_i,
    input  logic [NSTG-1:0] unblock_i,
    output logic [NSTG-1:0] bits_o,
    output logic [NSTG-1:0] bits_next_o
);

    logic [NSTG-1:0] bits_q;

    // Merge pulses into the held bits.
    always_comb begin
        bits_next_o = (bits_q | block_i) & ~(unblock_i & ~block_i);
    end

    // Hold the bits.
    always_ff @(posedge clk) begin
        if (!rst_n) bits_q <= '0;
        else        bits_q <= bits_next_o;
    end

    assign bits_o = bits_q;

    for (genvar s = 0; s < NSTG; s++) begin : g_chk
        p_stall_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
            block_i[s] |=> bits_q[s]);
        p_stall_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (unblock_i[s] && !block_i[s]) |=> !bits_q[s]);
        p_stall_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (!unblock_i[s] && !block_i[s]) |=> bits_q[s] == $past(bits_q[s]));
    end

endmodule

// File: rtl/fts_thread_fsm.sv
// Fetch status state machine of one thread.
// Priority per cycle: squash sources, then the wait/trap states,
// then stall, then return from Blocked/Squashing, then fetch-turn work.
// Assumes stalled_i already includes this cycle's stall pulses.
module fts_thread_fsm
    import fts_pkg::*;
#(
    parameter int ID_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            stalled_i,
    input  logic            cmt_squash_i,
    input  logic            still_squash_i,
    input  logic            dec_squash_i,
    input  logic            turn_me_i,
    input  logic            req_i,
    input  logic            req_accept_i,
    input  logic [ID_W-1:0] req_id_i,
    input  logic            cache_blocked_i,
    input  logic            retry_go_i,
    input  logic            resp_here_i,
    input  logic [ID_W-1:0] resp_id_i,
    input  logic            fault_i,
    input  logic            quiesce_i,
    input  logic            wake_i,
    output fstate_e         state_o,
    output logic            resp_hit_o,
    output logic            enter_retry_o,
    output logic            squash_evt_o
);

    fstate_e         state_q, state_d;
    logic [ID_W-1:0] id_q;
    logic            load_id;
    logic            any_squash;

    // Next-state selection in priority order.
    always_comb begin
        state_d       = state_q;
        load_id       = 1'b0;
        enter_retry_o = 1'b0;
        squash_evt_o  = 1'b0;
        any_squash    = cmt_squash_i | still_squash_i | dec_squash_i;
        resp_hit_o    = resp_here_i && (resp_id_i == id_q) &&
                        (state_q == ST_WAIT_RESP) && !any_squash;
        if (cmt_squash_i) begin
            state_d      = ST_SQUASH;
            squash_evt_o = 1'b1;
        end else if (still_squash_i || dec_squash_i) begin
            state_d      = ST_SQUASH;
            squash_evt_o = (state_q != ST_SQUASH);
        end else begin
            case (state_q)
                ST_WAIT_RESP: begin
                    if (resp_hit_o) state_d = stalled_i ? ST_BLOCKED : ST_ACC_DONE;
                end
                ST_WAIT_RETRY: begin
                    if (retry_go_i) state_d = ST_WAIT_RESP;
                end
                ST_TRAP, ST_QUIESCE: begin
                    if (wake_i) state_d = ST_RUN;
                end
                default: begin
                    if (stalled_i) begin
                        state_d = ST_BLOCKED;
                    end else if (state_q == ST_BLOCKED || state_q == ST_SQUASH) begin
                        state_d = ST_RUN;
                    end else if (state_q == ST_ACC_DONE) begin
                        if (turn_me_i) state_d = ST_RUN;
                    end else if (state_q == ST_RUN) begin
                        if (fault_i) begin
                            state_d = ST_TRAP;
                        end else if (quiesce_i) begin
                            state_d = ST_QUIESCE;
                        end else if (turn_me_i && req_i && !cache_blocked_i) begin
                            load_id = 1'b1;
                            if (req_accept_i) begin
                                state_d = ST_WAIT_RESP;
                            end else begin
                                state_d       = ST_WAIT_RETRY;
                                enter_retry_o = 1'b1;
                            end
                        end
                    end
                end
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // Outstanding request ID register.
    always_ff @(posedge clk) begin
        if (!rst_n)       id_q <= '0;
        else if (load_id) id_q <= req_id_i;
    end

    assign state_o = state_q;

    p_commit_squash_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cmt_squash_i |=> state_q == ST_SQUASH);
    p_still_squash_r4: assert property (@(posedge clk) disable iff (!rst_n)
        still_squash_i |=> state_q == ST_SQUASH);
    p_wait_resp_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_RESP && !resp_here_i && !cmt_squash_i &&
         !still_squash_i && !dec_squash_i) |=> state_q == ST_WAIT_RESP);
    p_trap_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TRAP && !wake_i && !cmt_squash_i && !still_squash_i &&
         !dec_squash_i) |=> state_q == ST_TRAP);
    p_quiesce_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_QUIESCE && !wake_i && !cmt_squash_i && !still_squash_i &&
         !dec_squash_i) |=> state_q == ST_QUIESCE);

endmodule

// File: rtl/fts_cache_track.sv
// Shared cache-blocked flag and the thread that owns the pending retry.
// Assumes at most one thread enters WaitRetry per cycle (single turn).
module fts_cache_track #(
    parameter int NT    = 4,
    parameter int TID_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NT-1:0]    enter_retry_i,
    input  logic [NT-1:0]    squash_evt_i,
    input  logic [TID_W-1:0] turn_tid_i,
    input  logic             retry_i,
    input  logic             retry_ok_i,
    output logic             blocked_o,
    output logic [NT-1:0]    retry_go_o
);

    logic             blocked_q;
    logic [TID_W-1:0] owner_q;
    logic             retry_done;

    assign retry_done = blocked_q && retry_i && retry_ok_i;

    // Decode the successful retry to the owning thread.
    for (genvar t = 0; t < NT; t++) begin : g_go
        assign retry_go_o[t] = retry_done && (owner_q == TID_W'(t));
    end

    // Set on a rejected send, clear on retry success or owner squash.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blocked_q <= 1'b0;
            owner_q   <= '0;
        end else if (|enter_retry_i) begin
            blocked_q <= 1'b1;
            owner_q   <= turn_tid_i;
        end else if (retry_done || (blocked_q && squash_evt_i[owner_q])) begin
            blocked_q <= 1'b0;
        end
    end

    assign blocked_o = blocked_q;

    p_block_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|enter_retry_i) |=> blocked_q);
    p_retry_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (retry_done && !(|enter_retry_i)) |=> !blocked_q);
    p_one_go_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(retry_go_o));

endmodule

// File: rtl/fetch_thread_status.sv
// Top of the per-thread fetch status controller: one stall-bit bank and
// one state machine per thread, one shared cache tracker.
// Assumes pulses are one cycle wide and turn_tid_i < NUM_THREADS.
module fetch_thread_status
    import fts_pkg::*;
#(
    parameter int NUM_THREADS = 4,
    parameter int REQ_ID_W    = 4,
    parameter int TID_W       = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_THREADS-1:0]        thread_active_i,
    input  logic [NUM_STAGES*NUM_THREADS-1:0] block_i,
    input  logic [NUM_STAGES*NUM_THREADS-1:0] unblock_i,
    input  logic                          ctx_switch_i,
    input  logic [NUM_THREADS-1:0]        commit_squash_i,
    input  logic [NUM_THREADS-1:0]        commit_still_squash_i,
    input  logic [NUM_THREADS-1:0]        decode_squash_i,
    input  logic                          turn_valid_i,
    input  logic [TID_W-1:0]              turn_tid_i,
    input  logic                          req_i,
    input  logic                          req_accept_i,
    input  logic [REQ_ID_W-1:0]           req_id_i,
    input  logic                          retry_i,
    input  logic                          retry_ok_i,
    input  logic                          resp_valid_i,
    input  logic [TID_W-1:0]              resp_tid_i,
    input  logic [REQ_ID_W-1:0]           resp_id_i,
    input  logic [NUM_THREADS-1:0]        fault_i,
    input  logic [NUM_THREADS-1:0]        quiesce_i,
    input  logic [NUM_THREADS-1:0]        wake_i,
    output logic [STATE_W*NUM_THREADS-1:0] status_o,
    output logic [NUM_STAGES*NUM_THREADS-1:0] stall_bits_o,
    output logic                          stage_active_o,
    output logic                          cache_blocked_o,
    output logic                          resp_drop_o
);

    localparam int NT = NUM_THREADS;

    logic [NT-1:0] enter_retry;
    logic [NT-1:0] squash_evt;
    logic [NT-1:0] retry_go;
    logic [NT-1:0] resp_hit;
    logic [NT-1:0] live;
    logic          cache_blocked;

    for (genvar t = 0; t < NT; t++) begin : g_thr
        logic [NUM_STAGES-1:0] bits_next;
        logic [NUM_STAGES-1:0] bits_cur;
        fstate_e               st;

        fts_stall_bits #(.NSTG(NUM_STAGES)) u_stall (
            .clk         (clk),
            .rst_n       (rst_n),
            .block_i     (block_i[t*NUM_STAGES +: NUM_STAGES]),
            .unblock_i   (unblock_i[t*NUM_STAGES +: NUM_STAGES]),
            .bits_o      (bits_cur),
            .bits_next_o (bits_next)
        );

        fts_thread_fsm #(.ID_W(REQ_ID_W)) u_fsm (
            .clk             (clk),
            .rst_n           (rst_n),
            .stalled_i       ((|bits_next) | ctx_switch_i),
            .cmt_squash_i    (commit_squash_i[t]),
            .still_squash_i  (commit_still_squash_i[t]),
            .dec_squash_i    (decode_squash_i[t]),
            .turn_me_i       (turn_valid_i && (turn_tid_i == TID_W'(t))),
            .req_i           (req_i),
            .req_accept_i    (req_accept_i),
            .req_id_i        (req_id_i),
            .cache_blocked_i (cache_blocked),
            .retry_go_i      (retry_go[t]),
            .resp_here_i     (resp_valid_i && (resp_tid_i == TID_W'(t))),
            .resp_id_i       (resp_id_i),
            .fault_i         (fault_i[t]),
            .quiesce_i       (quiesce_i[t]),
            .wake_i          (wake_i[t]),
            .state_o         (st),
            .resp_hit_o      (resp_hit[t]),
            .enter_retry_o   (enter_retry[t]),
            .squash_evt_o    (squash_evt[t])
        );

        assign status_o[t*STATE_W +: STATE_W]           = st;
        assign stall_bits_o[t*NUM_STAGES +: NUM_STAGES] = bits_cur;
        assign live[t] = thread_active_i[t] && is_live(st);
    end

    fts_cache_track #(.NT(NT), .TID_W(TID_W)) u_cache (
        .clk           (clk),
        .rst_n         (rst_n),
        .enter_retry_i (enter_retry),
        .squash_evt_i  (squash_evt),
        .turn_tid_i    (turn_tid_i),
        .retry_i       (retry_i),
        .retry_ok_i    (retry_ok_i),
        .blocked_o     (cache_blocked),
        .retry_go_o    (retry_go)
    );

    // Output decisions for the stage as a whole.
    always_comb begin
        stage_active_o  = |live;
        cache_blocked_o = cache_blocked;
        resp_drop_o     = resp_valid_i && !(|resp_hit);
    end

    p_stage_active_r10: assert property (@(posedge clk) disable iff (!rst_n)
        stage_active_o |-> (thread_active_i != '0));
    p_single_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(resp_hit));
    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (status_o == '0 && !cache_blocked_o));

endmodule

// File: tb/sim_fetch_thread_status.sv
// Bench for fetch_thread_status: table-driven stall/squash walk on thread 0,
// then directed cache, retry, trap and activity tests.
module sim_fetch_thread_status;

    localparam int NT  = 2;
    localparam int IDW = 3;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NT-1:0]  thread_active_i = '1;
    logic [4*NT-1:0] block_i = '0, unblock_i = '0;
    logic           ctx_switch_i = 1'b0;
    logic [NT-1:0]  commit_squash_i = '0, commit_still_squash_i = '0, decode_squash_i = '0;
    logic           turn_valid_i = 1'b0;
    logic           turn_tid_i = 1'b0;
    logic           req_i = 1'b0, req_accept_i = 1'b0;
    logic [IDW-1:0] req_id_i = '0;
    logic           retry_i = 1'b0, retry_ok_i = 1'b0;
    logic           resp_valid_i = 1'b0;
    logic           resp_tid_i = 1'b0;
    logic [IDW-1:0] resp_id_i = '0;
    logic [NT-1:0]  fault_i = '0, quiesce_i = '0, wake_i = '0;
    logic [4*NT-1:0] status_o;
    logic [4*NT-1:0] stall_bits_o;
    logic           stage_active_o, cache_blocked_o, resp_drop_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    fetch_thread_status #(.NUM_THREADS(NT), .REQ_ID_W(IDW)) u0 (
        .clk(clk), .rst_n(rst_n), .thread_active_i(thread_active_i),
        .block_i(block_i), .unblock_i(unblock_i), .ctx_switch_i(ctx_switch_i),
        .commit_squash_i(commit_squash_i), .commit_still_squash_i(commit_still_squash_i),
        .decode_squash_i(decode_squash_i), .turn_valid_i(turn_valid_i),
        .turn_tid_i(turn_tid_i), .req_i(req_i), .req_accept_i(req_accept_i),
        .req_id_i(req_id_i), .retry_i(retry_i), .retry_ok_i(retry_ok_i),
        .resp_valid_i(resp_valid_i), .resp_tid_i(resp_tid_i), .resp_id_i(resp_id_i),
        .fault_i(fault_i), .quiesce_i(quiesce_i), .wake_i(wake_i),
        .status_o(status_o), .stall_bits_o(stall_bits_o),
        .stage_active_o(stage_active_o), .cache_blocked_o(cache_blocked_o),
        .resp_drop_o(resp_drop_o)
    );

    // Vector: [15]commit squash [14]still [13]decode squash [12]ctx
    //         [11:8]block [7:4]unblock [3:0]expected thread-0 status
    localparam logic [15:0] VEC [16] = '{
        16'h0103, 16'h0003, 16'h0010, 16'h1003, 16'h0000, 16'h2002,
        16'h4002, 16'h0000, 16'h8802, 16'h0003, 16'h0080, 16'h2202,
        16'h0020, 16'hE002, 16'h4002, 16'h0000
    };

    function automatic int st(input int t);
        return int'(status_o[t*4 +: 4]);
    endfunction

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    task automatic clear_pulses();
        block_i = '0; unblock_i = '0; ctx_switch_i = 1'b0;
        commit_squash_i = '0; commit_still_squash_i = '0; decode_squash_i = '0;
        turn_valid_i = 1'b0; req_i = 1'b0; req_accept_i = 1'b0;
        retry_i = 1'b0; retry_ok_i = 1'b0; resp_valid_i = 1'b0;
        fault_i = '0; quiesce_i = '0; wake_i = '0;
    endtask

    // Inputs were set at a falling edge; pass one rising edge, clear, return.
    task automatic step();
        @(negedge clk);
        clear_pulses();
    endtask

    task automatic turn(input bit tid, input bit rq, input bit acc, input int id);
        turn_valid_i = 1'b1; turn_tid_i = tid; req_i = rq;
        req_accept_i = acc; req_id_i = IDW'(id);
    endtask

    task automatic resp(input bit tid, input int id);
        resp_valid_i = 1'b1; resp_tid_i = tid; resp_id_i = IDW'(id);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk(status_o == '0, "R1 reset status", int'(status_o), 0);
        chk(stall_bits_o == '0, "R1 reset stall bits", int'(stall_bits_o), 0);
        chk(cache_blocked_o == 1'b0, "R1 reset cache blocked", int'(cache_blocked_o), 0);
        chk(stage_active_o == 1'b1, "R10 active after reset", int'(stage_active_o), 1);

        // Table walk on thread 0: stalls (R2), squash priority (R3), hold (R4)
        for (int i = 0; i < 16; i++) begin
            commit_squash_i[0]       = VEC[i][15];
            commit_still_squash_i[0] = VEC[i][14];
            decode_squash_i[0]       = VEC[i][13];
            ctx_switch_i             = VEC[i][12];
            block_i[3:0]             = VEC[i][11:8];
            unblock_i[3:0]           = VEC[i][7:4];
            step();
            chk(st(0) == int'(VEC[i][3:0]), $sformatf("R2 R3 R4 table vec %0d", i),
                st(0), int'(VEC[i][3:0]));
        end
        chk(stall_bits_o == '0, "R2 bits clear after table", int'(stall_bits_o), 0);

        // R5 accepted request
        turn(0, 1, 1, 5); step();
        chk(st(0) == 4, "R5 accept to WaitResponse", st(0), 4);
        thread_active_i = 2'b01; #1;
        chk(stage_active_o == 1'b0, "R10 waiting thread is not live", int'(stage_active_o), 0);
        // R6 wrong ID dropped
        resp(0, 3); #1;
        chk(resp_drop_o == 1'b1, "R6 mismatched ID drop pulse", int'(resp_drop_o), 1);
        step();
        chk(st(0) == 4, "R6 mismatched ID keeps wait", st(0), 4);
        // R7 matching response, not stalled
        resp(0, 5); #1;
        chk(resp_drop_o == 1'b0, "R6 matching ID not dropped", int'(resp_drop_o), 0);
        step();
        chk(st(0) == 6, "R7 to AccessComplete", st(0), 6);
        chk(stage_active_o == 1'b1, "R10 AccessComplete is live", int'(stage_active_o), 1);
        thread_active_i = 2'b11;
        step();
        chk(st(0) == 6, "R7 holds without turn", st(0), 6);
        turn(0, 0, 0, 0); step();
        chk(st(0) == 0, "R7 turn returns to Running", st(0), 0);

        // R7 stalled while waiting, response goes to Blocked
        turn(0, 1, 1, 2); step();
        chk(st(0) == 4, "R5 second request", st(0), 4);
        block_i[2] = 1'b1; step();
        chk(st(0) == 4, "R7 stall ignored in WaitResponse", st(0), 4);
        chk(stall_bits_o[2] == 1'b1, "R2 execute stall bit set", int'(stall_bits_o[2]), 1);
        resp(0, 2); step();
        chk(st(0) == 3, "R7 stalled response to Blocked", st(0), 3);
        unblock_i[2] = 1'b1; step();
        chk(st(0) == 0, "R2 unblock returns to Running", st(0), 0);

        // R5 rejected send, R8 retry
        turn(1, 1, 0, 1); step();
        chk(st(1) == 5, "R5 reject to WaitRetry", st(1), 5);
        chk(cache_blocked_o == 1'b1, "R5 cache blocked set", int'(cache_blocked_o), 1);
        turn(0, 1, 1, 4); step();
        chk(st(0) == 0, "R5 request ignored while blocked", st(0), 0);
        retry_i = 1'b1; retry_ok_i = 1'b0; step();
        chk(st(1) == 5, "R8 failed retry keeps WaitRetry", st(1), 5);
        chk(cache_blocked_o == 1'b1, "R8 failed retry keeps flag", int'(cache_blocked_o), 1);
        retry_i = 1'b1; retry_ok_i = 1'b1; step();
        chk(st(1) == 4, "R8 retry to WaitResponse", st(1), 4);
        chk(cache_blocked_o == 1'b0, "R8 retry clears flag", int'(cache_blocked_o), 0);
        resp(1, 1); step();
        chk(st(1) == 6, "R6 retried ID accepted", st(1), 6);
        chk(st(0) == 0, "R6 other thread untouched", st(0), 0);
        turn(1, 0, 0, 0); step();
        chk(st(1) == 0, "R7 thread 1 back to Running", st(1), 0);

        // R8 squash of retrying thread clears flag
        turn(1, 1, 0, 6); step();
        chk(cache_blocked_o == 1'b1, "R5 flag set again", int'(cache_blocked_o), 1);
        commit_squash_i[1] = 1'b1; step();
        chk(st(1) == 2, "R3 squash from WaitRetry", st(1), 2);
        chk(cache_blocked_o == 1'b0, "R8 squash clears flag", int'(cache_blocked_o), 0);
        step();
        chk(st(1) == 0, "R2 Squashing to Running", st(1), 0);

        // R6 stale response after squash
        turn(1, 1, 1, 7); step();
        chk(st(1) == 4, "R5 thread 1 waits", st(1), 4);
        decode_squash_i[1] = 1'b1; step();
        chk(st(1) == 2, "R3 decode squash of waiting thread", st(1), 2);
        resp(1, 7); #1;
        chk(resp_drop_o == 1'b1, "R6 stale response drop pulse", int'(resp_drop_o), 1);
        step();
        chk(st(1) == 0, "R6 stale response not accepted", st(1), 0);

        // R9 trap and quiesce
        fault_i[0] = 1'b1; step();
        chk(st(0) == 7, "R9 fault to TrapPending", st(0), 7);
        block_i[0] = 1'b1; step();
        chk(st(0) == 7, "R9 stall ignored in trap", st(0), 7);
        unblock_i[0] = 1'b1; step();
        chk(st(0) == 7, "R9 trap held", st(0), 7);
        wake_i[0] = 1'b1; step();
        chk(st(0) == 0, "R9 wake to Running", st(0), 0);
        quiesce_i[1] = 1'b1; step();
        chk(st(1) == 8, "R9 quiesce to QuiescePending", st(1), 8);
        thread_active_i = 2'b10; #1;
        chk(stage_active_o == 1'b0, "R10 quiesced thread not live", int'(stage_active_o), 0);
        thread_active_i = 2'b11;
        decode_squash_i[1] = 1'b1; step();
        chk(st(1) == 2, "R9 squash leaves quiesce", st(1), 2);
        step();
        chk(st(1) == 0, "R2 thread 1 resumes", st(1), 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule